// File: doc/BRIEF.md
# Reset and Power-Down Pulse Classifier

This block watches one active-high control input and decides, from how long the input stays high, which of two jobs that input is asking for. A short assertion clears the input interface that deinterleaves and pairs the incoming samples. A long assertion puts the datapath into power-down until the input falls again. The input is first passed through a synchroniser. A saturating counter then measures the high time in clock cycles. A classifier turns the measured length into a one-cycle reset strobe, a sleep level and a one-cycle wake pulse.

The wake pulse marks the end of a power-down period. Downstream logic uses it to clear the sample-pairing state before normal traffic resumes. It is not used as a second reset strobe. When the control input is tied low, all outputs stay low. The threshold between a short and a long assertion is set by a parameter, with a default of four cycles.

Top module: `ctl_pulse_classifier`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `rst_o`, `sleep_o` and `wake_o` are all 0.
- R2: With `ctl_i` held at 0, the block never drives `rst_o`, `sleep_o` or `wake_o` high.
- R3: If `ctl_i` is high for 1 to 3 consecutive clock edges, the block emits exactly one `rst_o` pulse lasting one cycle. It does not assert `sleep_o` or `wake_o`.
- R4: If `ctl_i` is high for 4 or more consecutive clock edges, `sleep_o` is asserted and no `rst_o` pulse is emitted.
- R5: For a long assertion of N edges, `sleep_o` stays high for exactly N-3 cycles. It rises at the cycle the measured length reaches 4 and falls at the cycle after the synchronised input goes low.
- R6: When `sleep_o` falls, `wake_o` is high for exactly one cycle, and this clears the pairing logic. `wake_o` is never high at any other time.
- R7: The length counter saturates at 4. An assertion of 40 edges therefore keeps `sleep_o` high without any break and never produces a `rst_o` pulse.
- R8: `ctl_i` is first sampled low at some clock edge. For a short pulse, `rst_o` rises after the third clock edge counted from that edge: two edges are spent in the synchroniser and one in the output register. `wake_o` follows the same timing for a long assertion.
- R9: `rst_o` and `sleep_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 1 | Shared reset/power-down control, active high, asynchronous to the clock |
| rst_o | output | 1 | One-cycle reset strobe to the deinterleave and pairing logic |
| sleep_o | output | 1 | Power-down level |
| wake_o | output | 1 | One-cycle pulse at the end of power-down; clears the pairing logic |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, a four-cycle threshold and the wake output enabled. With these values, pulse lengths of 1, 3, 4, 5 and 40 edges fall on both sides of the classification boundary and well past the counter's saturation point. Each run counts the cycles in which every output is high and records the cycle in which the falling-edge response first appears. From these it checks the strobe count, the sleep length of N-3, the single wake pulse and the three-edge latency against values worked out by hand.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  function automatic int unsigned cnt_width(int unsigned limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctl_len_counter.sv
module ctl_len_counter #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned W = ctl_pkg::cnt_width(LIMIT)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lvl_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_next_o
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  always_comb begin
    if (!lvl_i)          cnt_next_o = '0;
    else if (cnt_o == LIM) cnt_next_o = LIM;
    else                 cnt_next_o = cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_next_o;
  end

  // R7: saturating count
  p_cnt_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= LIM);
  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && cnt_o == LIM) |=> cnt_o == LIM);
endmodule

// File: rtl/ctl_classify.sv
module ctl_classify #(
  parameter int unsigned LIMIT   = 4,
  parameter bit          WAKE_EN = 1'b1,
  localparam int unsigned W = ctl_pkg::cnt_width(LIMIT)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lvl_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cnt_next_i,
  output logic         rst_o,
  output logic         sleep_o,
  output logic         wake_o
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic rst_q, sleep_q, wake_q;
  logic ended;

  assign ended = !lvl_i && (cnt_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q   <= 1'b0;
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      rst_q  <= ended && (cnt_i < LIM);
      wake_q <= ended && sleep_q;
      if (lvl_i && cnt_next_i == LIM) sleep_q <= 1'b1;
      else if (!lvl_i)                sleep_q <= 1'b0;
    end
  end

  assign rst_o   = rst_q;
  assign sleep_o = sleep_q;

  if (WAKE_EN) begin : g_wake
    assign wake_o = wake_q;
  end else begin : g_no_wake
    assign wake_o = 1'b0;
  end

  // R9
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_q && sleep_q));
  // R3: strobe lasts one cycle
  p_one_shot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  // R5: sleep only entered at threshold
  p_sleep_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_q) |-> cnt_i == LIM);
  // R6: wake exactly when sleep drops
  p_wake_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_q) |-> wake_q);
  p_wake_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |-> $fell(sleep_q));
endmodule

// File: rtl/ctl_pulse_classifier.sv
module ctl_pulse_classifier #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LONG_CYCLES = 4,
  parameter bit          WAKE_EN     = 1'b1,
  localparam int unsigned CW = ctl_pkg::cnt_width(LONG_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_i,
  output logic rst_o,
  output logic sleep_o,
  output logic wake_o
);
  logic          lvl;
  logic [CW-1:0] cnt, cnt_next;

  ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ctl_i), .q_o(lvl)
  );

  ctl_len_counter #(.LIMIT(LONG_CYCLES)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl),
    .cnt_o(cnt), .cnt_next_o(cnt_next)
  );

  ctl_classify #(.LIMIT(LONG_CYCLES), .WAKE_EN(WAKE_EN)) u_cls (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl),
    .cnt_i(cnt), .cnt_next_i(cnt_next),
    .rst_o(rst_o), .sleep_o(sleep_o), .wake_o(wake_o)
  );

  // R2: idle synchronised input yields no action
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl && !$past(lvl) && !$past(lvl, 2)) |-> !(rst_o || sleep_o || wake_o));
endmodule

// File: tb/sim_ctl_pulse_classifier.sv
module sim_ctl_pulse_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl = 1'b0;
  logic rst_s, sleep_s, wake_s;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctl_pulse_classifier u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_i(ctl),
    .rst_o(rst_s), .sleep_o(sleep_s), .wake_o(wake_s)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "outputs in reset", {rst_s, sleep_s, wake_s}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after release", {rst_s, sleep_s, wake_s}, 0);
  endtask

  task automatic t_idle();
    int hits = 0;
    ctl = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rst_s || sleep_s || wake_s) hits++;
    end
    chk("R2", "activity with input low", hits, 0);
  endtask

  // drive a pulse of n edges and tally responses
  task automatic t_pulse(string req, int n);
    int n_rst = 0, n_sleep = 0, n_wake = 0, n_both = 0;
    int first_resp = -1, sleep_gap = 0;
    bit seen_sleep = 1'b0, left_sleep = 1'b0;
    bit long_p = (n >= 4);
    ctl = 1'b1;
    for (int i = 0; i < n + 12; i++) begin
      @(negedge clk);
      if (rst_s) n_rst++;
      if (sleep_s) begin
        n_sleep++;
        if (left_sleep) sleep_gap++;
        seen_sleep = 1'b1;
      end else if (seen_sleep) left_sleep = 1'b1;
      if (wake_s) n_wake++;
      if (rst_s && sleep_s) n_both++;
      if ((rst_s || wake_s) && first_resp < 0) first_resp = i;
      if (i == n - 1) ctl = 1'b0;
    end
    chk(req, $sformatf("rst pulses n=%0d", n), n_rst, long_p ? 0 : 1);
    chk(req, $sformatf("sleep cycles n=%0d", n), n_sleep, long_p ? n - 3 : 0);
    chk("R6", $sformatf("wake pulses n=%0d", n), n_wake, long_p ? 1 : 0);
    chk("R8", $sformatf("response cycle n=%0d", n), first_resp, n + 2);
    chk("R9", $sformatf("rst with sleep n=%0d", n), n_both, 0);
    if (long_p) chk("R7", $sformatf("sleep broken n=%0d", n), sleep_gap, 0);
  endtask

  task automatic t_mid_sleep();
    ctl = 1'b1;
    repeat (30) @(negedge clk);
    chk("R7", "sleep held after 30 edges", sleep_s, 1);
    chk("R7", "no strobe while held", rst_s, 0);
    ctl = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5", "sleep released", sleep_s, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_pulse("R3", 1);
    t_pulse("R3", 3);
    t_pulse("R4", 4);
    t_pulse("R5", 5);
    t_pulse("R7", 40);
    t_mid_sleep();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule